// File: doc/BRIEF.md
# Strobed Push-Button Key Encoder

This block turns eight raw push-button levels into a byte that polling software reads from an input port. Each button is synchronised to the system clock and then filtered: its clean level follows the raw level only after the raw level has held a new value for a programmable number of clocks. Seven of the filtered buttons carry the bits of a key code. The eighth button is a commit strobe.

When the filtered strobe goes from released to pressed, the seven code bits are captured into a register and a sticky "fresh key" flag is set. Software polls the port. The status byte carries the flag and the captured code. The flag is cleared by the read that returns it, so a second poll can tell a held key from a new one. A separate output always shows the live filtered level of all eight buttons.

This block has no streaming data path. Every pin is a plain level or a strobe, and the port read needs no handshake.

Top module: `strobe_key_encoder`

## Requirements
- R1: While reset is asserted and right after it is released, `port_status` reads 0x00 and `btn_live` reads 0x00, with every button taken as released.
- R2: A raw button level that differs from its filtered level for fewer than `DEB_CYCLES` consecutive clocks (after synchronisation) leaves the filtered level unchanged. A level held for longer than that is adopted.
- R3: `btn_live[i]` is the filtered level of `btn_raw[i]`. Bit 7 is the strobe button, bits 6..0 are the key code buttons, and 1 means pressed.
- R4: On a released-to-pressed change of the filtered strobe, `port_status[6:0]` takes the filtered levels of buttons 6..0, and `port_status[7]` (the fresh flag) becomes 1 on the next clock.
- R5: The captured code changes only at a strobe press. Changing the key buttons without a strobe press leaves `port_status[6:0]` unchanged.
- R6: A clock with `port_rd` high and no strobe press clears the fresh flag from the next clock onward. The captured code is kept.
- R7: When a strobe press and `port_rd` fall in the same clock, the press wins and the fresh flag is 1 after that clock.
- R8: Holding the strobe down gives exactly one capture. A further capture needs the strobe to be released and then pressed again.
- R9: A strobe glitch shorter than the filter window neither captures a code nor sets the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_raw | input | 8 | Raw button levels, 1 = pressed. Bit 7 is the strobe |
| port_rd | input | 1 | Input-port read strobe, one clock per read |
| port_status | output | 8 | {fresh flag, captured 7-bit code} |
| btn_live | output | 8 | Filtered live button levels |

## Verification
The main capture path is driven with a table of code patterns: all zeros, all ones, two alternating-bit patterns and two single-bit patterns. Together these separate stuck, swapped and shifted code bits, and show whether the flag comes from the strobe or from the code. Short pulses on both a key button and the strobe separate a working filter from a pass-through. A strobe held across many clocks while the keys change separates true edge detection from level-triggered capture. Holding `port_rd` high through a whole press shows that the flag is still seen exactly once, so a press in the same clock as a read is not lost.

// File: rtl/ske_pkg.sv
package ske_pkg;
  localparam int unsigned BTN_COUNT  = 8;
  localparam int unsigned CODE_BITS  = BTN_COUNT - 1;
  localparam int unsigned STROBE_IDX = BTN_COUNT - 1;

  typedef struct packed {
    logic                 fresh;
    logic [CODE_BITS-1:0] code;
  } key_status_t;
endpackage

// File: rtl/ske_deb_bit.sv
module ske_deb_bit #(
  parameter int unsigned DEB_CYCLES  = 65536,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw_in,
  output logic level_out
);
  localparam int unsigned CW = $clog2(DEB_CYCLES + 1);
  localparam logic [CW-1:0] LIMIT = CW'(DEB_CYCLES - 1);

  logic [SYNC_STAGES-1:0] sync_q;
  logic [CW-1:0]          run_cnt;
  logic                   level_q;
  logic                   sync_lvl;

  assign sync_lvl  = sync_q[SYNC_STAGES-1];
  assign level_out = level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q  <= '0;
      run_cnt <= '0;
      level_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[SYNC_STAGES-2:0], raw_in};
      if (sync_lvl == level_q) begin
        run_cnt <= '0;
      end else if (run_cnt == LIMIT) begin
        level_q <= sync_lvl;
        run_cnt <= '0;
      end else begin
        run_cnt <= run_cnt + 1'b1;
      end
    end
  end

  // R2: filtered level only ever moves toward the synchronised raw level
  p_follow_raw_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> (level_q == $past(sync_lvl)));

  // R2: a change of level restarts the run counter
  p_cnt_restart_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (level_q != $past(level_q)) |-> (run_cnt == '0));
endmodule

// File: rtl/ske_deb_bank.sv
module ske_deb_bank #(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned DEB_CYCLES  = 65536,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] raw_in,
  output logic [WIDTH-1:0] level_out
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    ske_deb_bit #(
      .DEB_CYCLES (DEB_CYCLES),
      .SYNC_STAGES(SYNC_STAGES)
    ) u_bit (
      .clk      (clk),
      .rst_n    (rst_n),
      .raw_in   (raw_in[g]),
      .level_out(level_out[g])
    );
  end
endmodule

// File: rtl/ske_capture.sv
module ske_capture
  import ske_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [BTN_COUNT-1:0] clean_btn,
  input  logic                 rd_pulse,
  output key_status_t          status
);
  logic                 strobe_prev;
  logic                 press_edge;
  logic                 fresh_q;
  logic [CODE_BITS-1:0] code_q;

  assign press_edge = clean_btn[STROBE_IDX] & ~strobe_prev;
  assign status     = '{fresh: fresh_q, code: code_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_prev <= 1'b0;
      fresh_q     <= 1'b0;
      code_q      <= '0;
    end else begin
      strobe_prev <= clean_btn[STROBE_IDX];
      if (press_edge) begin
        code_q  <= clean_btn[CODE_BITS-1:0];
        fresh_q <= 1'b1;
      end else if (rd_pulse) begin
        fresh_q <= 1'b0;
      end
    end
  end

  // R4: a press captures the live code bits and raises the flag
  p_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    press_edge |=> (fresh_q && code_q == $past(clean_btn[CODE_BITS-1:0])));

  // R5: without a press the code register holds
  p_code_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !press_edge |=> $stable(code_q));

  // R6: a read without a press clears the flag
  p_read_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && !press_edge) |=> !fresh_q);

  // R7: press in the same clock as a read still leaves the flag set
  p_press_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_pulse && press_edge) |=> fresh_q);

  // R8: a held strobe never yields two presses back to back
  p_one_press_r8: assert property (@(posedge clk) disable iff (!rst_n)
    press_edge |=> !press_edge);

  // R8: the flag can rise only through a press
  p_flag_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fresh_q) |-> $past(press_edge));
endmodule

// File: rtl/strobe_key_encoder.sv
module strobe_key_encoder
  import ske_pkg::*;
#(
  parameter int unsigned DEB_CYCLES  = 65536,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [7:0] btn_raw,
  input  logic       port_rd,
  output logic [7:0] port_status,
  output logic [7:0] btn_live
);
  logic [BTN_COUNT-1:0] clean_btn;
  key_status_t          stat;

  ske_deb_bank #(
    .WIDTH      (BTN_COUNT),
    .DEB_CYCLES (DEB_CYCLES),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_deb (
    .clk      (clk),
    .rst_n    (rst_n),
    .raw_in   (btn_raw),
    .level_out(clean_btn)
  );

  ske_capture u_cap (
    .clk      (clk),
    .rst_n    (rst_n),
    .clean_btn(clean_btn),
    .rd_pulse (port_rd),
    .status   (stat)
  );

  assign port_status = stat;
  assign btn_live    = clean_btn;

  // R1: outputs are clear in the first clock after reset release
  p_reset_clear_r1: assert property (@(posedge clk)
    (rst_n && !$past(rst_n)) |-> (port_status == 8'h00));

  // R5: key-button edges alone never move the captured code
  p_code_only_on_strobe_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(btn_live[STROBE_IDX]) |=> $stable(port_status[CODE_BITS-1:0]));
endmodule

// File: tb/strobe_key_encoder_bench.sv
module strobe_key_encoder_bench;
  localparam int unsigned DEB  = 8;
  localparam int unsigned SETL = 24;
  localparam int unsigned NV   = 6;
  localparam logic [6:0] CODES [NV] = '{7'h00, 7'h7F, 7'h55, 7'h2A, 7'h01, 7'h40};

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] btn_raw = 8'h00;
  logic       port_rd = 1'b0;
  logic [7:0] port_status;
  logic [7:0] btn_live;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  strobe_key_encoder #(.DEB_CYCLES(DEB), .SYNC_STAGES(2)) u_strobe_key_encoder (
    .clk(clk), .rst_n(rst_n), .btn_raw(btn_raw), .port_rd(port_rd),
    .port_status(port_status), .btn_live(btn_live)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_read();
    @(negedge clk) port_rd = 1'b1;
    @(negedge clk) port_rd = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int seen;
    // R1: reset state
    wait_cyc(3);
    chk("R1 status in reset", port_status, 8'h00);
    chk("R1 live in reset", btn_live, 8'h00);
    @(negedge clk) rst_n = 1'b1;
    wait_cyc(2);
    chk("R1 status after reset", port_status, 8'h00);

    // R4/R3/R6 table walk
    for (int v = 0; v < NV; v++) begin
      btn_raw = {1'b0, CODES[v]};
      wait_cyc(SETL);
      chk("R3 live code bits", btn_live, {1'b0, CODES[v]});
      btn_raw[7] = 1'b1;
      wait_cyc(SETL);
      chk("R3 live strobe bit", btn_live, {1'b1, CODES[v]});
      chk("R4 captured status", port_status, {1'b1, CODES[v]});
      do_read();
      wait_cyc(1);
      chk("R6 flag cleared, code kept", port_status, {1'b0, CODES[v]});
      btn_raw[7] = 1'b0;
      wait_cyc(SETL);
      chk("R8 release does not capture", port_status, {1'b0, CODES[v]});
    end

    // R2: short key pulse ignored, then long hold adopted
    btn_raw = 8'h00;
    wait_cyc(SETL);
    btn_raw[3] = 1'b1;
    wait_cyc(3);
    btn_raw[3] = 1'b0;
    wait_cyc(SETL);
    chk("R2 short pulse filtered", btn_live, 8'h00);
    btn_raw[3] = 1'b1;
    wait_cyc(4);
    chk("R2 not yet adopted", btn_live, 8'h00);
    wait_cyc(SETL);
    chk("R2 long hold adopted", btn_live, 8'h08);

    // R5: key change without strobe leaves code
    chk("R5 code unchanged by keys", port_status, {1'b0, CODES[NV-1]});

    // R9: short strobe glitch
    btn_raw[7] = 1'b1;
    wait_cyc(3);
    btn_raw[7] = 1'b0;
    wait_cyc(SETL);
    chk("R9 glitch no capture", port_status, {1'b0, CODES[NV-1]});
    chk("R9 glitch not live", btn_live, 8'h08);

    // R8: held strobe gives one capture
    btn_raw = 8'h80 | 8'h11;
    wait_cyc(SETL);
    chk("R8 first capture", port_status, 8'h91);
    do_read();
    btn_raw[6:0] = 7'h6E;
    wait_cyc(60);
    chk("R8 held strobe no recapture", port_status, 8'h11);
    btn_raw[7] = 1'b0;
    wait_cyc(SETL);
    btn_raw[7] = 1'b1;
    wait_cyc(SETL);
    chk("R8 repress captures", port_status, 8'hEE);
    btn_raw[7] = 1'b0;
    wait_cyc(SETL);
    do_read();

    // R7: read held through a press; flag must be seen once
    btn_raw[6:0] = 7'h33;
    wait_cyc(SETL);
    port_rd = 1'b1;
    btn_raw[7] = 1'b1;
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (port_status[7]) seen++;
    end
    port_rd = 1'b0;
    chk("R7 flag seen once under read", 8'(seen), 8'd1);
    chk("R7 code captured under read", port_status, 8'h33);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule